// File: doc/BRIEF.md
# Configurable logic cell

This block is a single programmable logic cell of the kind tiled across a reconfigurable array. It holds two 8-entry truth tables addressed by three operands. It can present them as two independent functions of the same three operands, or join them into one function of four operands. An optional AND gate in front of the tables replaces the first operand with the product of two inputs, which gives one bit of an array multiplier. A feedback path can replace the third operand with the cell's own register. A dedicated 2:1 selector can bypass the tables altogether.

The cell register captures the primary result on the rising clock edge. An asynchronous set/reset line forces it to a value chosen per cell. The main output shows either the combinational or the registered result, and a drive-enable output tells the surrounding fabric when the cell may drive a shared line. With suitable table contents, a row of cells forms a ripple adder (sum in one table, carry in the other) or a synchronous binary counter (next state in one table, carry in the other).

Configuration is written one word per clock: two table words and one control word.

Top module: `lcell_core`

## Requirements
- R1: A clock edge with `cfg_we` high stores `cfg_wdata` into table A when `cfg_addr` is 0, into table B when it is 1, and bits [6:0] into the control word when it is 2. Address 3 changes nothing. `rst_n` low clears both tables and the control word.
- R2: With control bits quad (bit 0), AND-front (bit 1), feedback (bit 2) and mux (bit 3) all clear, the index is {Z,Y,X}, with X as bit 0. `out_x` is table A at that index and `out_y` is table B at that index, and W has no effect.
- R3: With quad (control bit 0) set, `out_x` and `out_y` both equal table B at the index when W is 1, and table A at the index when W is 0.
- R4: With AND-front (control bit 1) set, index bit 0 is X AND W instead of X.
- R5: With feedback (control bit 2) set, index bit 2 is the cell register instead of Z.
- R6: With mux (control bit 3) set, `out_x` equals index bit 1 when index bit 2 is 1, and index bit 0 otherwise, whatever the tables hold. `out_y` is unaffected.
- R7: The register loads `out_x` on each rising clock edge. `cell_out` is the register when registered-output (control bit 4) is set, and `out_x` otherwise.
- R8: While `sr_n` is low, the register holds the value of control bit 5 (1 = set, 0 = reset) at once, with no clock edge needed.
- R9: `drv_en` is high exactly when output-enable (control bit 6) is set and `oe_in` is high.
- R10: Cells loaded with table A = 0x96, table B = 0xE8 and registered output, chained carry (`out_y`) to Z, compute A+B+carry-in. The sum bits appear on `cell_out` one clock later, and the final carry appears combinationally.
- R11: Cells loaded with table A = 0x78, table B = 0x80, feedback and registered output, with X as a common enable and carry chained into Y (1 at the first stage), count up by one per clock while enabled, hold while disabled, and wrap to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the register uses the rising edge |
| rst_n | input | 1 | Active-low asynchronous clear of the configuration |
| sr_n | input | 1 | Active-low asynchronous set/reset of the cell register |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration word select |
| cfg_wdata | input | 8 | Configuration write data |
| in_x | input | 1 | Operand X |
| in_y | input | 1 | Operand Y |
| in_w | input | 1 | Operand W (fourth table input or AND partner) |
| in_z | input | 1 | Operand Z |
| oe_in | input | 1 | Dynamic output enable from the fabric |
| out_x | output | 1 | Primary combinational result |
| out_y | output | 1 | Secondary combinational result (carry) |
| cell_out | output | 1 | Registered or combinational result |
| drv_en | output | 1 | Permission to drive a shared line |

## Verification
A vector table drives the sum and carry tables with operand sets whose indices differ only in one input. This separates W being ignored, W gating X through the AND gate, and W selecting the upper half of a four-input table. Selector vectors load a table that would give the opposite answer, so a design that reads the table instead of the bypass is exposed. A four-cell chain is checked as an adder on carry-free, full-ripple and all-ones operands, and a four-cell counter is checked across enable, hold and wrap-around. The asynchronous set and reset are sampled mid-cycle, before any clock edge.

// File: rtl/lcell_pkg.sv
package lcell_pkg;

  localparam int LUT_IN    = 3;
  localparam int TBL_W     = 1 << LUT_IN;
  localparam int N_TBL     = 2;
  localparam int CTRL_W    = 7;
  localparam int CFG_WORDS = N_TBL + 1;
  localparam int CFG_AW    = $clog2(CFG_WORDS + 1);
  localparam int CTRL_ADDR = N_TBL;

  typedef struct packed {
    logic oe_en;
    logic sr_set;
    logic reg_out;
    logic mux_en;
    logic fb_sel;
    logic and_en;
    logic quad;
  } cell_ctrl_t;

  function automatic logic tbl_pick(input logic [TBL_W-1:0] tbl,
                                    input logic [LUT_IN-1:0] idx);
    return tbl[idx];
  endfunction

  function automatic logic mux2(input logic sel, input logic d0, input logic d1);
    return sel ? d1 : d0;
  endfunction

  function automatic logic and_front(input logic en, input logic a, input logic b);
    return en ? (a & b) : a;
  endfunction

endpackage

// File: rtl/lcell_cfg.sv
module lcell_cfg
  import lcell_pkg::*;
#(
  parameter int WORD_W = TBL_W,
  parameter int AW     = CFG_AW,
  parameter int TBLS   = N_TBL,
  parameter int CW     = CTRL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] tbl_word [TBLS],
  output logic [CW-1:0]     ctrl_word
);

  localparam logic [AW-1:0] CTRL_SEL = AW'(TBLS);

  logic ctrl_hit;

  generate
    for (genvar i = 0; i < TBLS; i++) begin : g_tbl
      logic              hit;
      logic [WORD_W-1:0] word_q;
      assign hit = cfg_we && (cfg_addr == AW'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   word_q <= '0;
        else if (hit) word_q <= cfg_wdata;
      end
      assign tbl_word[i] = word_q;
    end
  endgenerate

  assign ctrl_hit = cfg_we && (cfg_addr == CTRL_SEL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctrl_word <= '0;
    else if (ctrl_hit) ctrl_word <= cfg_wdata[CW-1:0];
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(ctrl_word)) else $error("ctrl changed without write"); // R1
  AST_CFG_TBL0: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == '0) |=> tbl_word[0] == $past(cfg_wdata)) else $error("table A write lost"); // R1

endmodule

// File: rtl/lcell_front.sv
module lcell_front
  import lcell_pkg::*;
#(
  parameter int IDX_W = LUT_IN
) (
  input  logic             in_x,
  input  logic             in_y,
  input  logic             in_w,
  input  logic             in_z,
  input  logic             q_fb,
  input  logic             and_en,
  input  logic             fb_sel,
  output logic [IDX_W-1:0] idx
);

  logic op_a;
  logic op_c;

  assign op_a = and_front(and_en, in_x, in_w);
  assign op_c = mux2(fb_sel, in_z, q_fb);
  assign idx  = {op_c, in_y, op_a};

endmodule

// File: rtl/lcell_lut_pair.sv
module lcell_lut_pair
  import lcell_pkg::*;
#(
  parameter int IDX_W = LUT_IN,
  parameter int TBLS  = N_TBL,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] tbl_word [TBLS],
  input  logic [IDX_W-1:0] idx,
  input  logic             hi_sel,
  input  logic             quad,
  input  logic             mux_en,
  output logic             lut_x,
  output logic             lut_y
);

  logic [TBLS-1:0] rd;
  logic            quad_v;
  logic            bypass_v;

  generate
    for (genvar t = 0; t < TBLS; t++) begin : g_rd
      assign rd[t] = tbl_pick(tbl_word[t], idx);
    end
  endgenerate

  assign quad_v   = mux2(hi_sel, rd[0], rd[1]);
  assign bypass_v = mux2(idx[2], idx[0], idx[1]);

  always_comb begin
    if (mux_en)    lut_x = bypass_v;
    else if (quad) lut_x = quad_v;
    else           lut_x = rd[0];
    lut_y = quad ? quad_v : rd[1];
  end

  AST_QUAD_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    (quad && !mux_en) |-> lut_x == lut_y) else $error("quad outputs differ"); // R3
  AST_MUX_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_en && idx[0] == idx[1]) |-> lut_x == idx[0]) else $error("bypass mismatch"); // R6

endmodule

// File: rtl/lcell_reg.sv
module lcell_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic sr_n,
  input  logic sr_val,
  input  logic d,
  output logic q
);

  always_ff @(posedge clk or negedge sr_n) begin
    if (!sr_n) q <= sr_val;
    else       q <= d;
  end

  AST_SR_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_n |-> q == sr_val) else $error("set/reset not applied"); // R8
  AST_REG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n || !sr_n)
    $past(sr_n) |-> q == $past(d)) else $error("register missed edge"); // R7

endmodule

// File: rtl/lcell_core.sv
module lcell_core
  import lcell_pkg::*;
#(
  parameter int TW = TBL_W,
  parameter int AW = CFG_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sr_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [TW-1:0] cfg_wdata,
  input  logic          in_x,
  input  logic          in_y,
  input  logic          in_w,
  input  logic          in_z,
  input  logic          oe_in,
  output logic          out_x,
  output logic          out_y,
  output logic          cell_out,
  output logic          drv_en
);

  localparam int IDX_W = $clog2(TW);

  logic [TW-1:0]     tbl_word [N_TBL];
  logic [CTRL_W-1:0] ctrl_word;
  cell_ctrl_t        ctrl;
  logic [IDX_W-1:0]  ev_idx;
  logic              ev_q;
  logic              ev_lut_x;
  logic              ev_lut_y;

  lcell_cfg #(.WORD_W(TW), .AW(AW), .TBLS(N_TBL), .CW(CTRL_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .tbl_word  (tbl_word),
    .ctrl_word (ctrl_word)
  );

  assign ctrl = cell_ctrl_t'(ctrl_word);

  lcell_front #(.IDX_W(IDX_W)) u_front (
    .in_x   (in_x),
    .in_y   (in_y),
    .in_w   (in_w),
    .in_z   (in_z),
    .q_fb   (ev_q),
    .and_en (ctrl.and_en),
    .fb_sel (ctrl.fb_sel),
    .idx    (ev_idx)
  );

  lcell_lut_pair #(.IDX_W(IDX_W), .TBLS(N_TBL)) u_lut (
    .clk      (clk),
    .rst_n    (rst_n),
    .tbl_word (tbl_word),
    .idx      (ev_idx),
    .hi_sel   (in_w),
    .quad     (ctrl.quad),
    .mux_en   (ctrl.mux_en),
    .lut_x    (ev_lut_x),
    .lut_y    (ev_lut_y)
  );

  lcell_reg u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .sr_n   (sr_n),
    .sr_val (ctrl.sr_set),
    .d      (ev_lut_x),
    .q      (ev_q)
  );

  assign out_x    = ev_lut_x;
  assign out_y    = ev_lut_y;
  assign cell_out = mux2(ctrl.reg_out, ev_lut_x, ev_q);
  assign drv_en   = ctrl.oe_en & oe_in;

  AST_FB_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.fb_sel |-> ev_idx[IDX_W-1] == ev_q) else $error("feedback not in index"); // R5

endmodule

// File: tb/tb_lcell_core.sv
module tb_lcell_core;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       sr_n  = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       we_dut = 1'b0, we_add = 1'b0, we_cnt = 1'b0;
  logic       in_x = 1'b0, in_y = 1'b0, in_w = 1'b0, in_z = 1'b0, oe_in = 1'b0;
  logic       out_x, out_y, cell_out, drv_en;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  lcell_core dut (
    .clk(clk), .rst_n(rst_n), .sr_n(sr_n), .cfg_we(we_dut), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_x(in_x), .in_y(in_y), .in_w(in_w), .in_z(in_z),
    .oe_in(oe_in), .out_x(out_x), .out_y(out_y), .cell_out(cell_out), .drv_en(drv_en)
  );

  // four-cell ripple adder and four-cell counter
  logic [3:0] add_a = '0, add_b = '0;
  logic       add_cin = 1'b0;
  logic [3:0] add_carry, add_zin, add_sum, add_ox, add_de;
  logic       cnt_en = 1'b0;
  logic [3:0] cnt_carry, cnt_yin, cnt_val, cnt_ox, cnt_de;

  assign add_zin = {add_carry[2:0], add_cin};
  assign cnt_yin = {cnt_carry[2:0], 1'b1};

  for (genvar i = 0; i < 4; i++) begin : g_chain
    lcell_core add_cell (
      .clk(clk), .rst_n(rst_n), .sr_n(sr_n), .cfg_we(we_add), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .in_x(add_a[i]), .in_y(add_b[i]), .in_w(1'b0),
      .in_z(add_zin[i]), .oe_in(1'b0), .out_x(add_ox[i]), .out_y(add_carry[i]),
      .cell_out(add_sum[i]), .drv_en(add_de[i])
    );
    lcell_core cnt_cell (
      .clk(clk), .rst_n(rst_n), .sr_n(sr_n), .cfg_we(we_cnt), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .in_x(cnt_en), .in_y(cnt_yin[i]), .in_w(1'b0),
      .in_z(1'b0), .oe_in(1'b0), .out_x(cnt_ox[i]), .out_y(cnt_carry[i]),
      .cell_out(cnt_val[i]), .drv_en(cnt_de[i])
    );
  end

  // {table A, table B, ctrl[6:0], x y w z, exp out_x, exp out_y}
  localparam int NV = 13;
  localparam logic [28:0] VEC [NV] = '{
    {8'h96, 8'hE8, 7'h00, 4'b1100, 2'b01},  // R2 idx3
    {8'h96, 8'hE8, 7'h00, 4'b1101, 2'b11},  // R2 idx7
    {8'h96, 8'hE8, 7'h00, 4'b0001, 2'b10},  // R2 idx4
    {8'h96, 8'hE8, 7'h00, 4'b1010, 2'b10},  // R2 W ignored
    {8'h96, 8'hE8, 7'h02, 4'b1100, 2'b10},  // R4 X gated off by W=0
    {8'h96, 8'hE8, 7'h02, 4'b1110, 2'b01},  // R4 X passed by W=1
    {8'h00, 8'h80, 7'h01, 4'b1111, 2'b11},  // R3 upper half
    {8'h00, 8'h80, 7'h01, 4'b1101, 2'b00},  // R3 lower half
    {8'h00, 8'h80, 7'h00, 4'b1111, 2'b01},  // R3 contrast: split mode
    {8'h00, 8'h00, 7'h08, 4'b1000, 2'b10},  // R6 Z=0 picks X
    {8'h00, 8'h00, 7'h08, 4'b1001, 2'b00},  // R6 Z=1 picks Y=0
    {8'h00, 8'h00, 7'h08, 4'b0101, 2'b10},  // R6 Z=1 picks Y=1
    {8'hFF, 8'h00, 7'h08, 4'b0000, 2'b00}   // R6 table bypassed
  };

  function automatic string vec_tag(input int k);
    if (k < 4)       return "R2";
    else if (k < 6)  return "R4";
    else if (k < 9)  return "R3";
    else             return "R6";
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // grp: 0 dut, 1 adder chain, 2 counter chain
  task automatic cfg_wr(input int grp, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_addr  = a;
    cfg_wdata = d;
    we_dut = (grp == 0);
    we_add = (grp == 1);
    we_cnt = (grp == 2);
    @(negedge clk);
    we_dut = 1'b0; we_add = 1'b0; we_cnt = 1'b0;
  endtask

  task automatic cfg_cell(input int grp, input logic [7:0] ta, input logic [7:0] tb,
                          input logic [7:0] c);
    cfg_wr(grp, 2'd0, ta);
    cfg_wr(grp, 2'd1, tb);
    cfg_wr(grp, 2'd2, c);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    in_x = 1'b1; in_y = 1'b1; in_w = 1'b1; in_z = 1'b1; oe_in = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    sr_n = 1'b1;
    #2;
    // R1 reset clears configuration: outputs zero, no drive
    chk("R1 reset out_x", {7'd0, out_x}, 8'd0);
    chk("R1 reset out_y", {7'd0, out_y}, 8'd0);
    chk("R9 reset drv_en", {7'd0, drv_en}, 8'd0);

    // vector table
    for (int k = 0; k < NV; k++) begin
      cfg_cell(0, VEC[k][28:21], VEC[k][20:13], {1'b0, VEC[k][12:6]});
      {in_x, in_y, in_w, in_z} = VEC[k][5:2];
      #2;
      chk({vec_tag(k), " out_x"}, {7'd0, out_x}, {7'd0, VEC[k][1]});
      chk({vec_tag(k), " out_y"}, {7'd0, out_y}, {7'd0, VEC[k][0]});
    end

    // R1 address 3 is ignored
    cfg_cell(0, 8'h96, 8'hE8, 8'h00);
    cfg_wr(0, 2'd3, 8'hFF);
    {in_x, in_y, in_w, in_z} = 4'b1100;
    #2;
    chk("R1 addr3 out_x", {7'd0, out_x}, 8'd0);
    chk("R1 addr3 out_y", {7'd0, out_y}, 8'd1);
    chk("R1 addr3 cell_out", {7'd0, cell_out}, 8'd0);

    // R9 output enable
    cfg_wr(0, 2'd2, 8'h40);
    oe_in = 1'b1; #2;
    chk("R9 drv_en on", {7'd0, drv_en}, 8'd1);
    oe_in = 1'b0; #2;
    chk("R9 drv_en off", {7'd0, drv_en}, 8'd0);

    // R7 registered output lags by one edge; table A = X only
    cfg_cell(0, 8'hAA, 8'h00, 8'h10);
    {in_x, in_y, in_w, in_z} = 4'b0000;
    @(negedge clk);
    in_x = 1'b1; #2;
    chk("R7 comb out_x", {7'd0, out_x}, 8'd1);
    chk("R7 not yet loaded", {7'd0, cell_out}, 8'd0);
    @(negedge clk);
    chk("R7 loaded", {7'd0, cell_out}, 8'd1);
    cfg_wr(0, 2'd2, 8'h00);
    in_x = 1'b0; #2;
    chk("R7 comb select", {7'd0, cell_out}, 8'd0);

    // R8 asynchronous reset then set, sampled mid-cycle
    cfg_cell(0, 8'hFF, 8'h00, 8'h10);
    @(negedge clk);
    chk("R8 pre", {7'd0, cell_out}, 8'd1);
    sr_n = 1'b0; #2;
    chk("R8 async reset", {7'd0, cell_out}, 8'd0);
    @(negedge clk);
    sr_n = 1'b1;
    cfg_cell(0, 8'h00, 8'h00, 8'h30);
    @(negedge clk);
    chk("R8 pre set", {7'd0, cell_out}, 8'd0);
    sr_n = 1'b0; #2;
    chk("R8 async set", {7'd0, cell_out}, 8'd1);
    @(negedge clk);
    sr_n = 1'b1;

    // R5 feedback: table A = NOT index bit2 makes a toggle
    cfg_cell(0, 8'h0F, 8'h00, 8'h14);
    @(negedge clk);
    sr_n = 1'b0; @(negedge clk); sr_n = 1'b1;
    in_z = 1'b1;
    @(negedge clk);
    chk("R5 toggle 1", {7'd0, cell_out}, 8'd1);
    @(negedge clk);
    chk("R5 toggle 2", {7'd0, cell_out}, 8'd0);

    // R10 ripple adder
    cfg_cell(1, 8'h96, 8'hE8, 8'h10);
    begin
      logic [3:0] ta [6] = '{4'd3, 4'd15, 4'd15, 4'd9, 4'd0, 4'd10};
      logic [3:0] tb [6] = '{4'd5, 4'd1,  4'd15, 4'd6, 4'd0, 4'd5};
      logic       tc [6] = '{1'b0, 1'b0,  1'b1,  1'b1, 1'b0, 1'b0};
      for (int k = 0; k < 6; k++) begin
        logic [4:0] ref_sum;
        @(negedge clk);
        add_a = ta[k]; add_b = tb[k]; add_cin = tc[k];
        ref_sum = {1'b0, ta[k]} + {1'b0, tb[k]} + {4'd0, tc[k]};
        #2;
        chk("R10 carry out", {7'd0, add_carry[3]}, {7'd0, ref_sum[4]});
        @(negedge clk);
        chk("R10 sum", {4'd0, add_sum}, {4'd0, ref_sum[3:0]});
      end
    end

    // R11 counter
    cfg_cell(2, 8'h78, 8'h80, 8'h14);
    cnt_en = 1'b0;
    @(negedge clk);
    sr_n = 1'b0; #2;
    chk("R11 cleared", {4'd0, cnt_val}, 8'd0);
    @(negedge clk);
    sr_n = 1'b1;
    cnt_en = 1'b1;
    repeat (5) @(negedge clk);
    chk("R11 count 5", {4'd0, cnt_val}, 8'd5);
    cnt_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 hold", {4'd0, cnt_val}, 8'd5);
    cnt_en = 1'b1;
    repeat (13) @(negedge clk);
    chk("R11 wrap", {4'd0, cnt_val}, 8'd2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule